// File: doc/BRIEF.md
# Interrupt Mask with Context Save

This block sits between a processor core and its interrupt sources. It holds an 8-bit enable mask in which each bit admits one request line, and a global enable flag that the core sets and clears with separate commands. A request is offered to the core only when the line is pending, its mask bit is set, the global flag is on, and no post-push lockout is running. When several requests are open at once, the highest-numbered one is named as the winner.

To save and restore context, the core issues a push command. In that cycle the block places the current mask on a save port, and at the next edge it clears the mask. After a push, requests stay blocked for a short window, so the core can finish its save before any interrupt is taken. A pop command reloads the mask from a restore port.

Mask bit 0 does not watch a dedicated line. It stands for a shared line, built from a second-level pending register and a second-level mask. Events set bits in the second-level pending register, and software clears them by writing ones.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the following are all zero: the mask, the global enable, the second-level mask, the second-level pending register and every request output.
- R2: A mask write loads the write data into the mask at the next edge. Bits flagged as reserved (default: bits 7 and 6) are forced to 0 on every load.
- R3: The enable command sets the global flag and the disable command clears it, each at the next edge. If both arrive in the same cycle, disable wins. While the flag is clear, no request is raised.
- R4: In a push cycle, the save port shows the current mask value and the save-valid output is high. At the next edge the mask becomes 0.
- R5: For the 2 cycles after a push edge (parameter `LOCK_CYCLES`), the request-valid output stays low whatever the mask and pending inputs are.
- R6: A pop loads the restore data into the mask at the next edge, with reserved bits forced to 0.
- R7: A push overrides a pop and a mask write in the same cycle. A pop overrides a mask write in the same cycle.
- R8: Request bit 0 is the OR over all bits of (second-level pending AND second-level mask). Dedicated line `srcPend[k]` feeds request bit k+1.
- R9: A second-level event sets its pending bit at the next edge. A clear write with a 1 in a bit position clears that bit. If an event and a clear hit the same bit in the same cycle, the event wins.
- R10: The request vector equals (effective pending AND mask) when the global flag is set and no lockout is running. Otherwise it is 0. Request-valid is high exactly when the vector is non-zero.
- R11: The grant index is the highest-numbered set bit of the request vector, or 0 when the vector is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 8 | Mask write data |
| globEnCmd | input | 1 | Global enable command |
| globDisCmd | input | 1 | Global disable command |
| pushCmd | input | 1 | Push (save then clear mask) |
| popCmd | input | 1 | Pop (restore mask) |
| restoreData | input | 8 | Mask value to restore on pop |
| srcPend | input | 7 | Dedicated pending lines for request bits 7..1 |
| shEvent | input | 8 | Second-level source events |
| shMaskWrEn | input | 1 | Second-level mask write strobe |
| shMaskWrData | input | 8 | Second-level mask write data |
| shPendClrEn | input | 1 | Second-level pending clear strobe |
| shPendClrData | input | 8 | Write-1-to-clear pattern |
| saveData | output | 8 | Mask value offered for saving |
| saveValid | output | 1 | High in a push cycle |
| maskOut | output | 8 | Current mask |
| globEnOut | output | 1 | Current global enable |
| shMaskOut | output | 8 | Current second-level mask |
| shPendOut | output | 8 | Second-level pending (which shared source fired) |
| reqVec | output | 8 | Gated request vector |
| reqValid | output | 1 | Any request open |
| grantIdx | output | 3 | Highest-numbered open request |

## Verification
The following properties are checked on every cycle:
- the save port matches the mask in a push cycle;
- the mask is clear after a push;
- a pop loads the restore value;
- reserved mask bits stay zero;
- disable wins over enable;
- requests stay low while the global flag is off or a lockout is running;
- the grant points at a set request bit;
- an event is never lost to a same-cycle clear.

Some behaviours can only be shown by the bench's scenarios and its reference model. These are the exact priority among push, pop and write, the exact length of the lockout window with a pop inside it, and the full composition of the shared line from the two second-level registers under mixed traffic.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  // Strobes from the control section to the datapath and lockout logic.
  typedef struct packed {
    logic maskWr;     // load write data into mask
    logic maskPop;    // load restore data into mask
    logic maskClr;    // clear mask (push)
    logic geSet;      // set global enable
    logic geClr;      // clear global enable
    logic lockStart;  // start post-push lockout
  } irqStrobes_t;

endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int LOCK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        maskWrEn,
  input  logic        pushCmd,
  input  logic        popCmd,
  input  logic        globEnCmd,
  input  logic        globDisCmd,
  output irqStrobes_t stb,
  output logic        globEn,
  output logic        lockActive
);

  localparam int LW = $clog2(LOCK_CYCLES + 1);

  logic          geQ;
  logic [LW-1:0] lockCnt;

  // Command decode: push > pop > write; disable > enable.
  always_comb begin
    stb           = '0;
    stb.maskClr   = pushCmd;
    stb.maskPop   = popCmd && !pushCmd;
    stb.maskWr    = maskWrEn && !pushCmd && !popCmd;
    stb.geClr     = globDisCmd;
    stb.geSet     = globEnCmd && !globDisCmd;
    stb.lockStart = pushCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      geQ <= 1'b0;
    end else if (stb.geClr) begin
      geQ <= 1'b0;
    end else if (stb.geSet) begin
      geQ <= 1'b1;
    end
  end

  // Lockout window counter, reloaded on each push.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (stb.lockStart) begin
      lockCnt <= LW'(LOCK_CYCLES);
    end else if (lockCnt != '0) begin
      lockCnt <= lockCnt - 1'b1;
    end
  end

  assign globEn     = geQ;
  assign lockActive = (lockCnt != '0);

endmodule

// File: rtl/irq_mask_dp.sv
module irq_mask_dp
  import irq_mask_pkg::*;
#(
  parameter int                NUM_SRC   = 8,
  parameter int                SH_W      = 8,
  parameter logic [NUM_SRC-1:0] RSVD_BITS = 'hC0,
  parameter int                IW        = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        stb,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic [NUM_SRC-1:0] restoreData,
  input  logic               globEn,
  input  logic               lockActive,
  input  logic [NUM_SRC-2:0] srcPend,
  input  logic [SH_W-1:0]    shEvent,
  input  logic               shMaskWrEn,
  input  logic [SH_W-1:0]    shMaskWrData,
  input  logic               shPendClrEn,
  input  logic [SH_W-1:0]    shPendClrData,
  output logic [NUM_SRC-1:0] saveData,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [SH_W-1:0]    shMaskOut,
  output logic [SH_W-1:0]    shPendOut,
  output logic [NUM_SRC-1:0] reqVec,
  output logic               reqValid,
  output logic [IW-1:0]      grantIdx
);

  localparam logic [NUM_SRC-1:0] KEEP = ~RSVD_BITS;

  logic [NUM_SRC-1:0] maskQ;
  logic [SH_W-1:0]    shMaskQ;
  logic [SH_W-1:0]    shPendQ;
  logic [SH_W-1:0]    clrPat;
  logic               sharedLine;
  logic [NUM_SRC-1:0] effPend;
  logic               gateOpen;

  // First-level mask register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (stb.maskClr) begin
      maskQ <= '0;
    end else if (stb.maskPop) begin
      maskQ <= restoreData & KEEP;
    end else if (stb.maskWr) begin
      maskQ <= maskWrData & KEEP;
    end
  end

  // Second-level mask and pending pair.
  assign clrPat = shPendClrEn ? shPendClrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMaskQ <= '0;
      shPendQ <= '0;
    end else begin
      if (shMaskWrEn) shMaskQ <= shMaskWrData;
      shPendQ <= (shPendQ & ~clrPat) | shEvent;
    end
  end

  assign sharedLine = |(shPendQ & shMaskQ);

  // Effective pending vector: bit 0 shared, others dedicated.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    if (g == 0) begin : g_shared
      assign effPend[g] = sharedLine;
    end else begin : g_direct
      assign effPend[g] = srcPend[g-1];
    end
  end

  assign gateOpen = globEn && !lockActive;
  assign reqVec   = gateOpen ? (effPend & maskQ) : '0;
  assign reqValid = |reqVec;

  // Highest-numbered winner.
  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i]) grantIdx = IW'(i);
    end
  end

  assign saveData  = maskQ;
  assign maskOut   = maskQ;
  assign shMaskOut = shMaskQ;
  assign shPendOut = shPendQ;

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int                NUM_SRC     = 8,
  parameter int                SH_W        = 8,
  parameter logic [NUM_SRC-1:0] RSVD_BITS   = 'hC0,
  parameter int                LOCK_CYCLES = 2,
  parameter int                IW          = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               globEnCmd,
  input  logic               globDisCmd,
  input  logic               pushCmd,
  input  logic               popCmd,
  input  logic [NUM_SRC-1:0] restoreData,
  input  logic [NUM_SRC-2:0] srcPend,
  input  logic [SH_W-1:0]    shEvent,
  input  logic               shMaskWrEn,
  input  logic [SH_W-1:0]    shMaskWrData,
  input  logic               shPendClrEn,
  input  logic [SH_W-1:0]    shPendClrData,
  output logic [NUM_SRC-1:0] saveData,
  output logic               saveValid,
  output logic [NUM_SRC-1:0] maskOut,
  output logic               globEnOut,
  output logic [SH_W-1:0]    shMaskOut,
  output logic [SH_W-1:0]    shPendOut,
  output logic [NUM_SRC-1:0] reqVec,
  output logic               reqValid,
  output logic [IW-1:0]      grantIdx
);

  irqStrobes_t stb;
  logic        globEn;
  logic        lockActive;

  irq_mask_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .maskWrEn   (maskWrEn),
    .pushCmd    (pushCmd),
    .popCmd     (popCmd),
    .globEnCmd  (globEnCmd),
    .globDisCmd (globDisCmd),
    .stb        (stb),
    .globEn     (globEn),
    .lockActive (lockActive)
  );

  irq_mask_dp #(
    .NUM_SRC   (NUM_SRC),
    .SH_W      (SH_W),
    .RSVD_BITS (RSVD_BITS),
    .IW        (IW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .maskWrData    (maskWrData),
    .restoreData   (restoreData),
    .globEn        (globEn),
    .lockActive    (lockActive),
    .srcPend       (srcPend),
    .shEvent       (shEvent),
    .shMaskWrEn    (shMaskWrEn),
    .shMaskWrData  (shMaskWrData),
    .shPendClrEn   (shPendClrEn),
    .shPendClrData (shPendClrData),
    .saveData      (saveData),
    .maskOut       (maskOut),
    .shMaskOut     (shMaskOut),
    .shPendOut     (shPendOut),
    .reqVec        (reqVec),
    .reqValid      (reqValid),
    .grantIdx      (grantIdx)
  );

  assign saveValid = pushCmd;
  assign globEnOut = globEn;

endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int                NUM_SRC     = 8,
  parameter int                SH_W        = 8,
  parameter logic [NUM_SRC-1:0] RSVD_BITS   = 'hC0,
  parameter int                LOCK_CYCLES = 2,
  parameter int                IW          = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               pushCmd,
  input logic               popCmd,
  input logic               globDisCmd,
  input logic [NUM_SRC-1:0] restoreData,
  input logic [NUM_SRC-1:0] saveData,
  input logic               saveValid,
  input logic [NUM_SRC-1:0] maskOut,
  input logic               globEnOut,
  input logic [SH_W-1:0]    shEvent,
  input logic [SH_W-1:0]    shPendOut,
  input logic [NUM_SRC-1:0] reqVec,
  input logic               reqValid,
  input logic [IW-1:0]      grantIdx
);

  // Independent window counter for the lockout check.
  int lockLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lockLeft <= 0;
    else if (pushCmd)       lockLeft <= LOCK_CYCLES;
    else if (lockLeft != 0) lockLeft <= lockLeft - 1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (maskOut & RSVD_BITS) == '0);

  p_disable_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    globDisCmd |=> !globEnOut);

  p_ge_gates_r3: assert property (@(posedge clk) disable iff (!rstN)
    !globEnOut |-> !reqValid);

  p_save_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushCmd |-> (saveValid && saveData == maskOut));

  p_clear_after_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushCmd |=> maskOut == '0);

  p_lockout_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockLeft != 0) |-> !reqValid);

  p_pop_restore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popCmd && !pushCmd) |=> maskOut == ($past(restoreData) & ~RSVD_BITS));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (shPendOut & $past(shEvent)) == $past(shEvent));

  p_vec_within_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec & ~maskOut) == '0);

  p_valid_vec_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqVec != '0);

  p_grant_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqVec[grantIdx]);

endmodule

bind irq_mask_unit irq_mask_chk #(
  .NUM_SRC(NUM_SRC), .SH_W(SH_W), .RSVD_BITS(RSVD_BITS),
  .LOCK_CYCLES(LOCK_CYCLES), .IW(IW)
) u_chk (
  .clk(clk), .rstN(rstN), .pushCmd(pushCmd), .popCmd(popCmd),
  .globDisCmd(globDisCmd), .restoreData(restoreData), .saveData(saveData),
  .saveValid(saveValid), .maskOut(maskOut), .globEnOut(globEnOut),
  .shEvent(shEvent), .shPendOut(shPendOut), .reqVec(reqVec),
  .reqValid(reqValid), .grantIdx(grantIdx)
);

// File: tb/irq_mask_unit_tb.sv
`timescale 1ns/1ps
module irq_mask_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       maskWrEn = 0, globEnCmd = 0, globDisCmd = 0, pushCmd = 0, popCmd = 0;
  logic [7:0] maskWrData = 0, restoreData = 0;
  logic [6:0] srcPend = 0;
  logic [7:0] shEvent = 0, shMaskWrData = 0, shPendClrData = 0;
  logic       shMaskWrEn = 0, shPendClrEn = 0;
  logic [7:0] saveData, maskOut, shMaskOut, shPendOut, reqVec;
  logic       saveValid, globEnOut, reqValid;
  logic [2:0] grantIdx;

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] mMask, mShM, mShP;
  bit         mGe;
  int         mLock;
  localparam logic [7:0] RSVD = 8'hC0;
  localparam int LOCKN = 2;

  always #2 clk = ~clk;

  irq_mask_unit u_dut (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .globEnCmd(globEnCmd), .globDisCmd(globDisCmd), .pushCmd(pushCmd),
    .popCmd(popCmd), .restoreData(restoreData), .srcPend(srcPend),
    .shEvent(shEvent), .shMaskWrEn(shMaskWrEn), .shMaskWrData(shMaskWrData),
    .shPendClrEn(shPendClrEn), .shPendClrData(shPendClrData),
    .saveData(saveData), .saveValid(saveValid), .maskOut(maskOut),
    .globEnOut(globEnOut), .shMaskOut(shMaskOut), .shPendOut(shPendOut),
    .reqVec(reqVec), .reqValid(reqValid), .grantIdx(grantIdx)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 0; mShM = 0; mShP = 0; mGe = 0; mLock = 0;
    end else begin
      if (globDisCmd) mGe = 0; else if (globEnCmd) mGe = 1;
      if (pushCmd) mLock = LOCKN; else if (mLock > 0) mLock = mLock - 1;
      if (pushCmd) mMask = 0;
      else if (popCmd) mMask = restoreData & ~RSVD;
      else if (maskWrEn) mMask = maskWrData & ~RSVD;
      if (shPendClrEn) mShP = mShP & ~shPendClrData;
      mShP = mShP | shEvent;
      if (shMaskWrEn) mShM = shMaskWrData;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eff, rv;
    int g;
    eff = {srcPend, |(mShP & mShM)};
    rv  = (mGe && mLock == 0) ? (eff & mMask) : 8'h00;
    g = 0;
    for (int i = 0; i < 8; i++) if (rv[i]) g = i;
    check("R2 maskOut", maskOut, mMask);
    check("R3 globEnOut", globEnOut, mGe);
    check("R4 saveValid", saveValid, pushCmd);
    if (pushCmd) check("R4 saveData", saveData, mMask);
    check("R8 shMaskOut", shMaskOut, mShM);
    check("R9 shPendOut", shPendOut, mShP);
    check("R10 reqVec", reqVec, rv);
    check("R5 reqValid", reqValid, rv != 0);
    check("R11 grantIdx", grantIdx, g);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    maskWrEn = 0; globEnCmd = 0; globDisCmd = 0; pushCmd = 0; popCmd = 0;
    shMaskWrEn = 0; shPendClrEn = 0; shEvent = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1;
    #0.5;
    // R1: reset state
    check("R1 mask", maskOut, 0);
    check("R1 ge", globEnOut, 0);
    check("R1 shMask", shMaskOut, 0);
    check("R1 shPend", shPendOut, 0);
    check("R1 reqValid", reqValid, 0);
    check("R1 reqVec", reqVec, 0);

    // R2: reserved bits forced to zero
    maskWrEn = 1; maskWrData = 8'hFF; tick(); idle();
    check("R2 rsvd", maskOut, 8'h3F);

    // R3/R10/R11: enable and pending lines 2,3
    globEnCmd = 1; tick(); idle();
    srcPend = 7'b0000110; tick();
    check("R10 vec", reqVec, 8'h0C);
    check("R11 grant", grantIdx, 3);

    // R3: disable beats enable
    globEnCmd = 1; globDisCmd = 1; tick(); idle();
    check("R3 dis wins", globEnOut, 0);
    check("R3 no req", reqValid, 0);
    globEnCmd = 1; tick(); idle();

    // R4/R5/R6: push, pop inside the lockout window
    maskWrEn = 1; maskWrData = 8'h3E; tick(); idle();
    pushCmd = 1; #0.5;
    check("R4 save", saveData, 8'h3E);
    tick(); idle();
    check("R4 cleared", maskOut, 0);
    popCmd = 1; restoreData = 8'h3E; #0.5;
    check("R5 lock1", reqValid, 0);
    tick(); idle();
    check("R6 restore", maskOut, 8'h3E);
    check("R5 lock2", reqValid, 0);
    tick();
    check("R5 lock over", reqVec, 8'h0C);

    // R7: push beats pop and write
    pushCmd = 1; popCmd = 1; maskWrEn = 1; restoreData = 8'hFF; maskWrData = 8'hFF;
    tick(); idle();
    check("R7 push wins", maskOut, 0);
    tick(); tick();
    // R7: pop beats write
    popCmd = 1; maskWrEn = 1; restoreData = 8'h12; maskWrData = 8'h21; tick(); idle();
    check("R7 pop over write", maskOut, 8'h12);
    // R6: restore with reserved bits
    popCmd = 1; restoreData = 8'hFF; tick(); idle();
    check("R6 rsvd", maskOut, 8'h3F);

    // R8/R9: shared line
    srcPend = 0;
    shMaskWrEn = 1; shMaskWrData = 8'h05; tick(); idle();
    shEvent = 8'h04; tick(); idle();
    check("R8 shared", reqVec, 8'h01);
    check("R11 grant0", grantIdx, 0);
    shEvent = 8'h04; shPendClrEn = 1; shPendClrData = 8'h04; tick(); idle();
    check("R9 event wins", shPendOut, 8'h04);
    shPendClrEn = 1; shPendClrData = 8'h04; tick(); idle();
    check("R9 cleared", shPendOut, 0);
    check("R8 no shared", reqValid, 0);
    shEvent = 8'h02; tick(); idle();
    check("R8 masked 2nd", reqValid, 0);
    check("R9 pend shows", shPendOut, 8'h02);

    // Mixed traffic against the model
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      maskWrEn    = (lfsr[3:0] == 0);
      maskWrData  = lfsr[15:8];
      globEnCmd   = (lfsr[6:4] == 1);
      globDisCmd  = (lfsr[9:7] == 2);
      pushCmd     = (lfsr[13:10] == 3);
      popCmd      = (lfsr[17:14] == 4);
      restoreData = lfsr[31:24];
      srcPend     = lfsr[22:16];
      shEvent     = (lfsr[20:18] == 0) ? lfsr[27:20] : 8'h00;
      shMaskWrEn  = (lfsr[25:23] == 5);
      shMaskWrData = lfsr[7:0];
      shPendClrEn = (lfsr[29:27] == 6);
      shPendClrData = lfsr[23:16];
      tick();
    end
    idle();

    done = 1;
    summary();
    $finish;
  end

endmodule